// File: doc/BRIEF.md
# Ethernet PHY Basic Mode Control Register

This block holds the basic mode control word of a 10/100 Ethernet transceiver and drives the control lines that follow from it. Software reaches it through a plain 16-bit register port: a write strobe with write data, and a combinational read value. The serial management framing sits outside the block. The analog line interface and the auto-negotiation engine also sit outside. The negotiated speed and duplex arrive as two input pins.

The word carries six controls: a self-clearing software reset, loopback, forced speed and duplex, auto-negotiation enable, power-down and isolate.
- While auto-negotiation is on, the speed and duplex bits read back the negotiated result and drive the speed and duplex controls.
- When the word is isolated, a small gate on the media-independent interface floats the receive data and clock outputs.
- When the word is powered down, the same gate forces the receive data outputs low.
- Turning loopback on at 100 Mbps blanks receive data-valid for a dead time. The dead time and the reset duration are counted in clock cycles, and both counts are parameters.

Top module: `phy_bctl_reg`

## Requirements
- R1: After `rst_n` is released, the register holds its default word and reads it back:
  - bit 12 (auto-negotiation on) is 1;
  - bit 13 shows `an_speed_100`;
  - bit 8 shows `an_full_dup`;
  - bit 10 follows R9;
  - every other bit is 0.
- R2: A write with bit 15 set, accepted while idle, starts a software reset. Bit 15 of the readback and `soft_rst_active` read 1 for exactly RST_CYCLES cycles, starting the cycle after the write, and then return to 0. During the reset every control sits at its default: loopback 0, speed bit 1, auto-negotiation 1, power-down 0, duplex bit 0, isolate per R9.
- R3: Any write made while the software reset is running has no effect.
- R4: A write with bit 15 set ignores every other bit written with it.
- R5: While bit 12 is 1, readback bits 13 and 8 and the outputs `ctl_speed_100` and `ctl_full_dup` follow `an_speed_100` and `an_full_dup`.
- R6: While bit 12 is 0, the last written bit 13 (1 = 100 Mbps) and bit 8 (1 = full duplex) set the readback and the speed and duplex outputs.
- R7: The bits below take effect in the cycle after an accepted write and read back as written:
  - bit 14 drives `ctl_loopback`;
  - bit 11 drives `ctl_pwr_down`;
  - bit 10 drives `ctl_isolate`.

  Bits 9 and 7..0 always read 0.
- R8: While bit 10 is 1:
  - `mii_out_en` is 0;
  - all `mii_*` clock and data outputs are high impedance;
  - the register port still reads and writes normally.
- R9: At hardware or software reset, the isolate bit defaults to 1 when `strap_phyad` is all zeros, and to 0 otherwise.
- R10: When `ctl_loopback` rises while the effective speed is 100 Mbps, `mii_rx_dv` is held 0 for exactly DEAD_CYCLES cycles. The hold starts in the cycle after the write. A rise at 10 Mbps causes no hold. A software reset ends the hold.
- R11: While powered down and not isolated, `mii_rx_dv`, `mii_rx_er`, `mii_rxd`, `mii_col` and `mii_crs` are 0. The two clock outputs still pass through.
- R12: When the block is not isolated, not powered down and not in a dead time, every `mii_*` output equals its `core_*` input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management clock |
| rst_n | input | 1 | Active-low hardware reset |
| strap_phyad | input | PHYAD_W | Strapped PHY address |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register readback |
| an_speed_100 | input | 1 | Negotiated speed, 1 = 100 Mbps |
| an_full_dup | input | 1 | Negotiated duplex, 1 = full |
| soft_rst_active | output | 1 | Software reset in progress; resets sibling registers |
| ctl_loopback | output | 1 | Loopback enable |
| ctl_speed_100 | output | 1 | Effective speed |
| ctl_full_dup | output | 1 | Effective duplex |
| ctl_an_en | output | 1 | Auto-negotiation enable |
| ctl_pwr_down | output | 1 | Power-down enable |
| ctl_isolate | output | 1 | Isolate enable |
| core_tx_clk | input | 1 | Transmit clock from the core |
| core_rx_clk | input | 1 | Receive clock from the core |
| core_rx_dv | input | 1 | Receive data valid from the core |
| core_rx_er | input | 1 | Receive error from the core |
| core_rxd | input | RXD_W | Receive data from the core |
| core_col | input | 1 | Collision from the core |
| core_crs | input | 1 | Carrier sense from the core |
| mii_out_en | output | 1 | 1 while the MII outputs are driven |
| mii_tx_clk | output | 1 | MII transmit clock |
| mii_rx_clk | output | 1 | MII receive clock |
| mii_rx_dv | output | 1 | MII receive data valid |
| mii_rx_er | output | 1 | MII receive error |
| mii_rxd | output | RXD_W | MII receive data |
| mii_col | output | 1 | MII collision |
| mii_crs | output | 1 | MII carrier sense |

## Verification
The control word lives in one flop set, and the readback, the control pins and the MII gate all decode it. A stored bit that is wrong therefore shows in the read value one cycle after the write that set it.

A reset counter that is off by one stretches or shortens the stretch of bit 15 at 1. A dead-time counter that is off by one shifts the cycle in which `mii_rx_dv` comes back. Both errors appear the moment the count ends.

A wrong selection between stored and negotiated speed shows at once when `an_speed_100` toggles.

// File: rtl/phy_bctl_pkg.sv
package phy_bctl_pkg;

   localparam int unsigned BCTL_W = 16;

   // Bit positions are decoded by management software; keep them fixed.
   localparam int unsigned B_RST = 15;
   localparam int unsigned B_LB  = 14;
   localparam int unsigned B_SPD = 13;
   localparam int unsigned B_AN  = 12;
   localparam int unsigned B_PD  = 11;
   localparam int unsigned B_ISO = 10;
   localparam int unsigned B_DUP = 8;

   typedef struct packed {
      logic loopback;
      logic speed_100;
      logic an_en;
      logic pwr_down;
      logic isolate;
      logic full_dup;
   } bctl_fields_t;

   function automatic bctl_fields_t bctl_defaults(input logic iso_dflt);
      bctl_fields_t f;
      f.loopback  = 1'b0;
      f.speed_100 = 1'b1;
      f.an_en     = 1'b1;
      f.pwr_down  = 1'b0;
      f.isolate   = iso_dflt;
      f.full_dup  = 1'b0;
      return f;
   endfunction

   function automatic bctl_fields_t bctl_decode(input logic [BCTL_W-1:0] w);
      bctl_fields_t f;
      f.loopback  = w[B_LB];
      f.speed_100 = w[B_SPD];
      f.an_en     = w[B_AN];
      f.pwr_down  = w[B_PD];
      f.isolate   = w[B_ISO];
      f.full_dup  = w[B_DUP];
      return f;
   endfunction

   function automatic logic [BCTL_W-1:0] bctl_encode(input logic busy,
                                                     input bctl_fields_t f);
      logic [BCTL_W-1:0] w;
      w        = '0;
      w[B_RST] = busy;
      w[B_LB]  = f.loopback;
      w[B_SPD] = f.speed_100;
      w[B_AN]  = f.an_en;
      w[B_PD]  = f.pwr_down;
      w[B_ISO] = f.isolate;
      w[B_DUP] = f.full_dup;
      return w;
   endfunction

endpackage

// File: rtl/phy_bctl_rstseq.sv
module phy_bctl_rstseq #(
   parameter int unsigned RST_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int unsigned CNT_W = $clog2(RST_CYCLES + 1);

   logic [CNT_W-1:0] cnt_q;

   generate
      if (RST_CYCLES < 1) begin : g_bad_len
         $error("phy_bctl_rstseq: RST_CYCLES must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= CNT_W'(RST_CYCLES);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign busy = (cnt_q != '0);

endmodule

// File: rtl/phy_bctl_deadtime.sv
module phy_bctl_deadtime #(
   parameter int unsigned DEAD_CYCLES = 72_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic loopback,
   input  logic speed_100,
   output logic rx_blank
);
   localparam int unsigned CNT_W = (DEAD_CYCLES > 1) ? $clog2(DEAD_CYCLES) : 1;

   logic [CNT_W-1:0] cnt_q;
   logic             lb_prev_q;
   logic             start;

   generate
      if (DEAD_CYCLES < 1) begin : g_bad_len
         $error("phy_bctl_deadtime: DEAD_CYCLES must be at least 1");
      end
   endgenerate

   // The first blanked cycle is the one in which loopback is first seen high.
   assign start = loopback && !lb_prev_q && speed_100;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         lb_prev_q <= 1'b0;
      end else begin
         lb_prev_q <= loopback;
         if (clr) begin
            cnt_q <= '0;
         end else if (start) begin
            cnt_q <= CNT_W'(DEAD_CYCLES - 1);
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
         end
      end
   end

   assign rx_blank = start || (cnt_q != '0);

endmodule

// File: rtl/phy_bctl_mii_gate.sv
module phy_bctl_mii_gate #(
   parameter int unsigned RXD_W = 4
) (
   input  logic             isolate,
   input  logic             pwr_down,
   input  logic             rx_blank,
   input  logic             core_tx_clk,
   input  logic             core_rx_clk,
   input  logic             core_rx_dv,
   input  logic             core_rx_er,
   input  logic [RXD_W-1:0] core_rxd,
   input  logic             core_col,
   input  logic             core_crs,
   output logic             mii_out_en,
   output logic             mii_tx_clk,
   output logic             mii_rx_clk,
   output logic             mii_rx_dv,
   output logic             mii_rx_er,
   output logic [RXD_W-1:0] mii_rxd,
   output logic             mii_col,
   output logic             mii_crs
);
   logic drive;
   logic data_on;

   generate
      if (RXD_W < 1) begin : g_bad_w
         $error("phy_bctl_mii_gate: RXD_W must be at least 1");
      end
   endgenerate

   assign drive   = !isolate;
   assign data_on = !pwr_down;

   assign mii_out_en = drive;
   assign mii_tx_clk = drive ? core_tx_clk : 1'bz;
   assign mii_rx_clk = drive ? core_rx_clk : 1'bz;
   assign mii_rx_dv  = drive ? (data_on && !rx_blank && core_rx_dv) : 1'bz;
   assign mii_rx_er  = drive ? (data_on && core_rx_er) : 1'bz;
   assign mii_col    = drive ? (data_on && core_col) : 1'bz;
   assign mii_crs    = drive ? (data_on && core_crs) : 1'bz;

   for (genvar i = 0; i < RXD_W; i++) begin : g_rxd
      assign mii_rxd[i] = drive ? (data_on && core_rxd[i]) : 1'bz;
   end

endmodule

// File: rtl/phy_bctl_reg.sv
module phy_bctl_reg
   import phy_bctl_pkg::*;
#(
   parameter int unsigned REG_W        = 16,
   parameter int unsigned PHYAD_W      = 5,
   parameter int unsigned RXD_W        = 4,
   parameter int unsigned RST_CYCLES   = 64,
   parameter int unsigned DEAD_CYCLES  = 72_000_000,
   parameter bit          ISO_STRAP_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PHYAD_W-1:0] strap_phyad,
   input  logic               reg_wr_en,
   input  logic [REG_W-1:0]   reg_wdata,
   output logic [REG_W-1:0]   reg_rdata,
   input  logic               an_speed_100,
   input  logic               an_full_dup,
   output logic               soft_rst_active,
   output logic               ctl_loopback,
   output logic               ctl_speed_100,
   output logic               ctl_full_dup,
   output logic               ctl_an_en,
   output logic               ctl_pwr_down,
   output logic               ctl_isolate,
   input  logic               core_tx_clk,
   input  logic               core_rx_clk,
   input  logic               core_rx_dv,
   input  logic               core_rx_er,
   input  logic [RXD_W-1:0]   core_rxd,
   input  logic               core_col,
   input  logic               core_crs,
   output logic               mii_out_en,
   output logic               mii_tx_clk,
   output logic               mii_rx_clk,
   output logic               mii_rx_dv,
   output logic               mii_rx_er,
   output logic [RXD_W-1:0]   mii_rxd,
   output logic               mii_col,
   output logic               mii_crs
);
   generate
      if (REG_W != BCTL_W) begin : g_bad_reg_w
         $error("phy_bctl_reg: REG_W must equal the 16-bit register width");
      end
      if (PHYAD_W < 1) begin : g_bad_ad_w
         $error("phy_bctl_reg: PHYAD_W must be at least 1");
      end
   endgenerate

   logic         iso_dflt;
   logic         rst_busy;
   logic         rst_start;
   logic         rx_blank;
   bctl_fields_t fld_q;
   bctl_fields_t fld_view;
   logic         wdata_unused;

   // Isolate default variant: follow the address strap or fix at 0.
   generate
      if (ISO_STRAP_EN) begin : g_iso_strap
         assign iso_dflt = (strap_phyad == '0);
      end else begin : g_iso_fixed
         assign iso_dflt = 1'b0;
      end
   endgenerate

   assign wdata_unused = ^{reg_wdata[9], reg_wdata[7:0]};

   // Reset request wins over every other bit of the same write.
   assign rst_start = reg_wr_en && reg_wdata[B_RST] && !rst_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fld_q <= bctl_defaults(iso_dflt);
      end else if (rst_start || rst_busy) begin
         fld_q <= bctl_defaults(iso_dflt);
      end else if (reg_wr_en) begin
         fld_q <= bctl_decode(reg_wdata);
      end
   end

   always_comb begin
      fld_view = fld_q;
      if (fld_q.an_en) begin
         fld_view.speed_100 = an_speed_100;
         fld_view.full_dup  = an_full_dup;
      end
   end

   assign reg_rdata       = bctl_encode(rst_busy, fld_view);
   assign soft_rst_active = rst_busy;
   assign ctl_loopback    = fld_view.loopback;
   assign ctl_speed_100   = fld_view.speed_100;
   assign ctl_full_dup    = fld_view.full_dup;
   assign ctl_an_en       = fld_view.an_en;
   assign ctl_pwr_down    = fld_view.pwr_down;
   assign ctl_isolate     = fld_view.isolate;

   phy_bctl_rstseq #(
      .RST_CYCLES (RST_CYCLES)
   ) u_rstseq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (rst_start),
      .busy  (rst_busy)
   );

   phy_bctl_deadtime #(
      .DEAD_CYCLES (DEAD_CYCLES)
   ) u_deadtime (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (rst_start),
      .loopback  (fld_view.loopback),
      .speed_100 (fld_view.speed_100),
      .rx_blank  (rx_blank)
   );

   phy_bctl_mii_gate #(
      .RXD_W (RXD_W)
   ) u_gate (
      .isolate     (fld_view.isolate),
      .pwr_down    (fld_view.pwr_down),
      .rx_blank    (rx_blank),
      .core_tx_clk (core_tx_clk),
      .core_rx_clk (core_rx_clk),
      .core_rx_dv  (core_rx_dv),
      .core_rx_er  (core_rx_er),
      .core_rxd    (core_rxd),
      .core_col    (core_col),
      .core_crs    (core_crs),
      .mii_out_en  (mii_out_en),
      .mii_tx_clk  (mii_tx_clk),
      .mii_rx_clk  (mii_rx_clk),
      .mii_rx_dv   (mii_rx_dv),
      .mii_rx_er   (mii_rx_er),
      .mii_rxd     (mii_rxd),
      .mii_col     (mii_col),
      .mii_crs     (mii_crs)
   );

endmodule

// File: rtl/phy_bctl_chk.sv
module phy_bctl_chk #(
   parameter int unsigned RXD_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr_en,
   input logic [15:0]      reg_wdata,
   input logic [15:0]      reg_rdata,
   input logic             an_speed_100,
   input logic             an_full_dup,
   input logic             soft_rst_active,
   input logic             ctl_loopback,
   input logic             ctl_speed_100,
   input logic             ctl_full_dup,
   input logic             ctl_an_en,
   input logic             ctl_pwr_down,
   input logic             ctl_isolate,
   input logic             mii_out_en,
   input logic             mii_rx_dv,
   input logic             mii_rx_er,
   input logic [RXD_W-1:0] mii_rxd,
   input logic             mii_col,
   input logic             mii_crs
);

   a_r2_busy_flag: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_active == reg_rdata[15]);

   a_r2_reset_reads_one: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_wdata[15] && !reg_rdata[15]) |=> reg_rdata[15]);

   a_r2_defaults_held: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[15] |-> (!ctl_loopback && !ctl_pwr_down && ctl_an_en));

   a_r3_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[15] && reg_wr_en) |=>
         $stable({ctl_loopback, ctl_an_en, ctl_pwr_down, ctl_isolate}));

   a_r4_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_wdata[15] && !reg_rdata[15]) |=>
         (!ctl_loopback && !ctl_pwr_down && ctl_an_en));

   a_r5_an_readback: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_an_en |-> (reg_rdata[13] == an_speed_100 && reg_rdata[8] == an_full_dup
                     && ctl_speed_100 == an_speed_100 && ctl_full_dup == an_full_dup));

   a_r6_forced_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && !reg_rdata[15] && !reg_wdata[15] && !reg_wdata[12]) |=>
         (ctl_speed_100 == $past(reg_wdata[13]) && ctl_full_dup == $past(reg_wdata[8])));

   a_r7_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[9] == 1'b0 && reg_rdata[7:0] == 8'h00));

   a_r8_isolate_oe: assert property (@(posedge clk) disable iff (!rst_n)
      (mii_out_en != reg_rdata[10]) && (ctl_isolate == reg_rdata[10]));

   a_r10_loop_blank: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ctl_loopback) && ctl_speed_100 && mii_out_en) |-> !mii_rx_dv);

   a_r11_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_pwr_down && mii_out_en) |->
         (!mii_rx_dv && !mii_rx_er && !mii_col && !mii_crs && mii_rxd == '0));

endmodule

bind phy_bctl_reg phy_bctl_chk #(.RXD_W(RXD_W)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .reg_wr_en       (reg_wr_en),
   .reg_wdata       (reg_wdata),
   .reg_rdata       (reg_rdata),
   .an_speed_100    (an_speed_100),
   .an_full_dup     (an_full_dup),
   .soft_rst_active (soft_rst_active),
   .ctl_loopback    (ctl_loopback),
   .ctl_speed_100   (ctl_speed_100),
   .ctl_full_dup    (ctl_full_dup),
   .ctl_an_en       (ctl_an_en),
   .ctl_pwr_down    (ctl_pwr_down),
   .ctl_isolate     (ctl_isolate),
   .mii_out_en      (mii_out_en),
   .mii_rx_dv       (mii_rx_dv),
   .mii_rx_er       (mii_rx_er),
   .mii_rxd         (mii_rxd),
   .mii_col         (mii_col),
   .mii_crs         (mii_crs)
);

// File: tb/phy_bctl_reg_tb.sv
`timescale 1ns/1ps
module phy_bctl_reg_tb;
   localparam int RST_C  = 6;
   localparam int DEAD_C = 20;
   localparam int RXD_W  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [4:0]       strap_phyad = 5'd0;
   logic             reg_wr_en = 1'b0;
   logic [15:0]      reg_wdata = '0;
   logic [15:0]      reg_rdata;
   logic             an_speed_100 = 1'b1, an_full_dup = 1'b1;
   logic             soft_rst_active, ctl_loopback, ctl_speed_100, ctl_full_dup;
   logic             ctl_an_en, ctl_pwr_down, ctl_isolate;
   logic             core_tx_clk = 0, core_rx_clk = 0, core_rx_dv = 0, core_rx_er = 0;
   logic [RXD_W-1:0] core_rxd = '0;
   logic             core_col = 0, core_crs = 0;
   logic             mii_out_en, mii_tx_clk, mii_rx_clk, mii_rx_dv, mii_rx_er;
   logic [RXD_W-1:0] mii_rxd;
   logic             mii_col, mii_crs;

   phy_bctl_reg #(.RST_CYCLES(RST_C), .DEAD_CYCLES(DEAD_C), .RXD_W(RXD_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .strap_phyad(strap_phyad),
      .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .an_speed_100(an_speed_100), .an_full_dup(an_full_dup),
      .soft_rst_active(soft_rst_active), .ctl_loopback(ctl_loopback),
      .ctl_speed_100(ctl_speed_100), .ctl_full_dup(ctl_full_dup),
      .ctl_an_en(ctl_an_en), .ctl_pwr_down(ctl_pwr_down), .ctl_isolate(ctl_isolate),
      .core_tx_clk(core_tx_clk), .core_rx_clk(core_rx_clk), .core_rx_dv(core_rx_dv),
      .core_rx_er(core_rx_er), .core_rxd(core_rxd), .core_col(core_col), .core_crs(core_crs),
      .mii_out_en(mii_out_en), .mii_tx_clk(mii_tx_clk), .mii_rx_clk(mii_rx_clk),
      .mii_rx_dv(mii_rx_dv), .mii_rx_er(mii_rx_er), .mii_rxd(mii_rxd),
      .mii_col(mii_col), .mii_crs(mii_crs));

   int  n_run = 0, n_fail = 0;
   bit  done = 0;
   bit  force_dv = 0;

   // Bench model of the register
   logic m_lb, m_spd, m_an, m_pd, m_iso, m_dup;
   int   m_busy = 0, m_dead = 0;

   function automatic logic eff_spd();
      return m_an ? an_speed_100 : m_spd;
   endfunction
   function automatic logic eff_dup();
      return m_an ? an_full_dup : m_dup;
   endfunction
   function automatic logic [15:0] exp_rd();
      logic [15:0] w = '0;
      w[15] = (m_busy > 0); w[14] = m_lb; w[13] = eff_spd(); w[12] = m_an;
      w[11] = m_pd; w[10] = m_iso; w[8] = eff_dup();
      return w;
   endfunction
   function automatic logic [6:0] exp_ctl();
      return {m_busy > 0, m_lb, eff_spd(), m_an, m_pd, m_iso, eff_dup()};
   endfunction
   function automatic logic [9:0] exp_mii();
      logic q = !m_pd;
      return {core_tx_clk, core_rx_clk, q && (m_dead == 0) && core_rx_dv,
              q && core_rx_er, core_rxd & {RXD_W{q}}, q && core_col, q && core_crs};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic set_defaults();
      m_lb = 0; m_spd = 1; m_an = 1; m_pd = 0; m_iso = (strap_phyad == 5'd0); m_dup = 0;
   endtask

   task automatic model_edge(input logic wr, input logic [15:0] wd);
      logic lb_before = m_lb;
      logic strobe = 0;
      if (m_busy > 0) m_busy--;
      else if (wr && wd[15]) begin set_defaults(); m_busy = RST_C; strobe = 1; end
      else if (wr) begin
         m_lb = wd[14]; m_spd = wd[13]; m_an = wd[12];
         m_pd = wd[11]; m_iso = wd[10]; m_dup = wd[8];
      end
      if (strobe) m_dead = 0;
      else if (m_lb && !lb_before && eff_spd()) m_dead = DEAD_C;
      else if (m_dead > 0) m_dead--;
   endtask

   task automatic compare_all(input string tag);
      check(tag, reg_rdata, exp_rd());
      check(tag, {soft_rst_active, ctl_loopback, ctl_speed_100, ctl_an_en,
                  ctl_pwr_down, ctl_isolate, ctl_full_dup}, exp_ctl());
      if (m_iso) check("R8", mii_out_en, 1'b0);
      else begin
         check("R8", mii_out_en, 1'b1);
         check(m_pd ? "R11" : (m_dead > 0 ? "R10" : "R12"),
               {mii_tx_clk, mii_rx_clk, mii_rx_dv, mii_rx_er, mii_rxd, mii_col, mii_crs},
               exp_mii());
      end
   endtask

   task automatic do_cycle(input logic wr, input logic [15:0] wd, input string tag);
      reg_wr_en = wr; reg_wdata = wd;
      {core_tx_clk, core_rx_clk, core_rx_dv, core_rx_er, core_col, core_crs} = 6'($urandom);
      core_rxd = RXD_W'($urandom);
      if (force_dv) core_rx_dv = 1'b1;
      @(posedge clk);
      model_edge(wr, wd);
      @(negedge clk);
      reg_wr_en = 1'b0;
      compare_all(tag);
   endtask

   task automatic hw_reset(input logic [4:0] strap);
      rst_n = 1'b0; strap_phyad = strap;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      set_defaults(); m_busy = 0; m_dead = 0;
      #0.1;
      compare_all("R1");
      check("R9", reg_rdata[10], (strap == 5'd0));
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed));
      @(negedge clk);
      // R1, R9: strap zero gives isolate
      hw_reset(5'd0);
      // R6: forced 10M half, then 100M full
      do_cycle(1, 16'h0000, "R6");
      do_cycle(1, 16'h2100, "R6");
      // R7: loopback/pd/isolate readback; unused bits read 0
      do_cycle(1, 16'h03FF, "R7");
      check("R7", {reg_rdata[9], reg_rdata[7:0]}, 9'h000);
      do_cycle(1, 16'h4800, "R7");
      // R4: reset with other bits set
      do_cycle(1, 16'hDD00, "R4");
      check("R4", {ctl_loopback, ctl_pwr_down, ctl_an_en}, 3'b001);
      // R2, R3: busy window, writes ignored
      for (int i = 0; i < RST_C + 2; i++) do_cycle((i == 2), 16'h4C00, (i == 2) ? "R3" : "R2");
      // R5: negotiated result tracking
      for (int i = 0; i < 4; i++) begin
         an_speed_100 = i[0]; an_full_dup = i[1];
         do_cycle(0, 16'h0, "R5");
      end
      an_speed_100 = 1'b1;
      // R8: isolate, register port still works
      do_cycle(1, 16'h0400, "R8");
      do_cycle(1, 16'h0500, "R8");
      // R10: dead time at forced 100M
      force_dv = 1;
      do_cycle(1, 16'h2000, "R10");
      do_cycle(1, 16'h6000, "R10");
      for (int i = 0; i < DEAD_C + 3; i++) do_cycle(0, 16'h0, "R10");
      // R10: no dead time at 10M
      do_cycle(1, 16'h0000, "R10");
      do_cycle(1, 16'h4000, "R10");
      check("R10", mii_rx_dv, 1'b1);
      // R10: software reset ends the hold
      do_cycle(1, 16'h2000, "R10");
      do_cycle(1, 16'h6000, "R10");
      do_cycle(1, 16'h8000, "R10");
      for (int i = 0; i < RST_C + 1; i++) do_cycle(0, 16'h0, "R10");
      force_dv = 0;
      // R11: power-down quiet
      do_cycle(1, 16'h0800, "R11");
      do_cycle(0, 16'h0, "R11");
      // R9: nonzero strap
      hw_reset(5'd9);
      // Random mix
      for (int i = 0; i < 4000; i++) begin
         logic wr = ($urandom_range(3) == 0);
         logic [15:0] wd = 16'($urandom);
         if ($urandom_range(15) != 0) wd[15] = 1'b0;
         if ($urandom_range(7) == 0) begin
            an_speed_100 = 1'($urandom); an_full_dup = 1'($urandom);
         end
         do_cycle(wr, wd, m_an ? "R5" : "R6");
      end
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule